// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square N×N matrices of signed 8-bit values on a mesh of N×N multiply-accumulate cells that all advance together on one clock. The upper operand matrix U is pushed in through the top edge one row per cycle, and its values fall one cell per cycle. The left operand matrix V is pushed in through the left edge one column per cycle, and its values move one cell per cycle to the right. Each edge has a skew stage, so lane j is delayed by j cycles. Because of this, element V[i][k] and element U[k][j] reach cell (i,j) in the same cycle. The cell multiplies them and adds the product into its own accumulator.

A single pulse on `start_i` begins a job. The block then tells the environment which operand index to present by raising `feed_en_o` with a matching `feed_k_o`, and it injects zeros on every other cycle. After 3N−2 compute cycles, each cell holds one element of the product R = V×U. These results are not read out in parallel. They shift downward through the mesh, and the bottom edge emits one full row per cycle, bottom row first. A one-cycle `done_o` pulse closes the job.

Top module: `mesh_matmul`

## Requirements
- R1: While reset is asserted, and right after it is released, `busy_o`, `done_o`, `res_valid_o` and `feed_en_o` are 0.
- R2: A start is accepted only when the block is idle, and is sampled at a clock edge. In the N cycles that directly follow that edge, `feed_en_o` is 1 and `feed_k_o` counts 0, 1, …, N−1. In every other cycle `feed_en_o` is 0.
- R3: Every emitted result element R[i][j] equals the sum over k of V[i][k]·U[k][j]. Operands are signed two's complement (DW=8 bits) and results are signed two's complement in AW=20 bits. In the cycle that carries index k, `top_row_i[j*8 +: 8]` holds U[k][j] and `left_col_i[i*8 +: 8]` holds V[i][k].
- R4: `res_valid_o` is 1 for exactly N consecutive cycles, beginning 3N−2 cycles after the start edge. In those cycles `res_row_o` counts down from N−1 to 0. Lane j of `res_data_o` (bits `[j*20 +: 20]`) carries R[`res_row_o`][j].
- R5: `done_o` is 1 for exactly one cycle, the cycle right after the last result row. `busy_o` is 1 from the cycle after the start edge through the `done_o` cycle, and 0 otherwise.
- R6: A start that arrives while `busy_o` is 1, including the `done_o` cycle, is ignored. The job in progress keeps its sequence and results.
- R7: Operand port values in cycles where `feed_en_o` is 0 have no effect on any result, because zeros are injected instead.
- R8: Each job's results depend only on its own operands. A start accepted in the first idle cycle after a job yields that job's product alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Job start request, taken only when idle |
| top_row_i | input | N*DW | Row `feed_k_o` of U, lane j = column j |
| left_col_i | input | N*DW | Column `feed_k_o` of V, lane i = row i |
| feed_en_o | output | 1 | Operand ports are sampled this cycle |
| feed_k_o | output | clog2(N) | Operand index requested this cycle |
| busy_o | output | 1 | A job is in progress |
| res_valid_o | output | 1 | `res_data_o` carries a result row |
| res_row_o | output | clog2(N) | Index of the row on `res_data_o` |
| res_data_o | output | N*AW | Result row, lane j = column j, zero when not valid |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
Take the clock edge that accepts a start as edge 0. The operand request for index k is then due in the cycle after edge k. Result row N−1−d is due in the cycle after edge 3N−2+d. `done_o` is due after edge 4N−2, and the block is idle again after edge 4N−1. The bench keeps a counter of edges since the accepted start and updates it at each rising edge. It derives every expected output from that counter and compares them at each falling edge, so it reads the registered values halfway between edges. Operand ports carry zeros, all-ones or random values outside the feed window. Start is also held high across a whole job, so ignored starts and an immediate follow-on job land at known edges.

// File: rtl/mm_pkg.sv
package mm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_COMP  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_FIN   = 2'd3
   } mm_state_e;

endpackage

// File: rtl/mm_seq_ctrl.sv
module mm_seq_ctrl
   import mm_pkg::*;
#(
   parameter int N = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          clr_o,
   output logic          mac_en_o,
   output logic          shift_o,
   output logic          feed_en_o,
   output logic [$clog2(N)-1:0] feed_k_o,
   output logic          res_valid_o,
   output logic [$clog2(N)-1:0] res_row_o,
   output logic          done_o,
   output logic          busy_o
);

   localparam int KW         = $clog2(N);
   localparam int CW         = $clog2(3 * N);
   localparam int COMP_LAST  = 3 * N - 3;
   localparam int DRAIN_LAST = N - 1;

   mm_state_e      state_q;
   logic [CW-1:0]  cnt_q;
   logic           accept;

   assign accept = start_i && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (accept) state_q <= ST_COMP;
            end
            ST_COMP: begin
               if (cnt_q == CW'(COMP_LAST)) begin
                  cnt_q   <= '0;
                  state_q <= ST_DRAIN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (cnt_q == CW'(DRAIN_LAST)) begin
                  cnt_q   <= '0;
                  state_q <= ST_FIN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               cnt_q   <= '0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign clr_o       = accept;
   assign mac_en_o    = (state_q == ST_COMP);
   assign shift_o     = (state_q == ST_DRAIN);
   assign feed_en_o   = (state_q == ST_COMP) && (cnt_q < CW'(N));
   assign feed_k_o    = cnt_q[KW-1:0];
   assign res_valid_o = (state_q == ST_DRAIN);
   assign res_row_o   = KW'(N - 1) - cnt_q[KW-1:0];
   assign done_o      = (state_q == ST_FIN);
   assign busy_o      = (state_q != ST_IDLE);

endmodule

// File: rtl/mm_edge_seq.sv
module mm_edge_seq #(
   parameter int LANES = 4,
   parameter int DW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              feed_en_i,
   input  logic [LANES*DW-1:0] lanes_i,
   output logic [LANES*DW-1:0] lanes_o
);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [DW-1:0] src;
      // zero filler outside the operand window
      assign src = feed_en_i ? lanes_i[j*DW +: DW] : '0;

      if (j == 0) begin : g_direct
         assign lanes_o[j*DW +: DW] = src;
      end else begin : g_skew
         logic [DW-1:0] dly_q [j];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < j; s++) dly_q[s] <= '0;
            end else if (clr_i) begin
               for (int s = 0; s < j; s++) dly_q[s] <= '0;
            end else begin
               dly_q[0] <= src;
               for (int s = 1; s < j; s++) dly_q[s] <= dly_q[s-1];
            end
         end
         assign lanes_o[j*DW +: DW] = dly_q[j-1];
      end
   end

endmodule

// File: rtl/mm_cell.sv
module mm_cell #(
   parameter int DW = 8,
   parameter int AW = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 mac_en_i,
   input  logic                 shift_i,
   input  logic [DW-1:0]        west_i,
   input  logic [DW-1:0]        north_i,
   input  logic signed [AW-1:0] acc_up_i,
   output logic [DW-1:0]        east_o,
   output logic [DW-1:0]        south_o,
   output logic signed [AW-1:0] acc_o
);

   logic signed [2*DW-1:0] prod;
   logic signed [AW-1:0]   prod_x;
   logic signed [AW-1:0]   acc_q;
   logic [DW-1:0]          east_q;
   logic [DW-1:0]          south_q;

   assign prod   = $signed(west_i) * $signed(north_i);
   assign prod_x = prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         east_q  <= '0;
         south_q <= '0;
      end else if (clr_i) begin
         acc_q   <= '0;
         east_q  <= '0;
         south_q <= '0;
      end else begin
         east_q  <= west_i;
         south_q <= north_i;
         if (mac_en_i)     acc_q <= acc_q + prod_x;
         else if (shift_i) acc_q <= acc_up_i;
      end
   end

   assign east_o  = east_q;
   assign south_o = south_q;
   assign acc_o   = acc_q;

endmodule

// File: rtl/mesh_matmul.sv
module mesh_matmul #(
   parameter int N  = 4,
   parameter int DW = 8,
   parameter int AW = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [N*DW-1:0]      top_row_i,
   input  logic [N*DW-1:0]      left_col_i,
   output logic                 feed_en_o,
   output logic [$clog2(N)-1:0] feed_k_o,
   output logic                 busy_o,
   output logic                 res_valid_o,
   output logic [$clog2(N)-1:0] res_row_o,
   output logic [N*AW-1:0]      res_data_o,
   output logic                 done_o
);

   if (N < 2) begin : g_bad_n
      $error("mesh_matmul: N must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("mesh_matmul: DW must be at least 2");
   end
   if (AW < 2 * DW) begin : g_bad_aw
      $error("mesh_matmul: AW must hold a full product");
   end

   logic clr, mac_en, shift;
   logic [N*DW-1:0] top_skew, left_skew;
   logic [N*DW-1:0] east_edge, south_edge;

   logic [DW-1:0]        hz   [N][N+1];
   logic [DW-1:0]        vt   [N+1][N];
   logic signed [AW-1:0] accw [N+1][N];

   mm_seq_ctrl #(.N(N)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .clr_o       (clr),
      .mac_en_o    (mac_en),
      .shift_o     (shift),
      .feed_en_o   (feed_en_o),
      .feed_k_o    (feed_k_o),
      .res_valid_o (res_valid_o),
      .res_row_o   (res_row_o),
      .done_o      (done_o),
      .busy_o      (busy_o)
   );

   mm_edge_seq #(.LANES(N), .DW(DW)) u_top_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .feed_en_i (feed_en_o),
      .lanes_i   (top_row_i),
      .lanes_o   (top_skew)
   );

   mm_edge_seq #(.LANES(N), .DW(DW)) u_left_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .feed_en_i (feed_en_o),
      .lanes_i   (left_col_i),
      .lanes_o   (left_skew)
   );

   for (genvar e = 0; e < N; e++) begin : g_edges
      assign vt[0][e]   = top_skew[e*DW +: DW];
      assign hz[e][0]   = left_skew[e*DW +: DW];
      assign accw[0][e] = '0;
      assign east_edge[e*DW +: DW]  = hz[e][N];
      assign south_edge[e*DW +: DW] = vt[N][e];
      assign res_data_o[e*AW +: AW] = res_valid_o ? accw[N][e] : '0;
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         mm_cell #(.DW(DW), .AW(AW)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .mac_en_i (mac_en),
            .shift_i  (shift),
            .west_i   (hz[i][j]),
            .north_i  (vt[i][j]),
            .acc_up_i (accw[i][j]),
            .east_o   (hz[i][j+1]),
            .south_o  (vt[i+1][j]),
            .acc_o    (accw[i+1][j])
         );
      end
   end

endmodule

// File: rtl/mesh_matmul_chk.sv
module mesh_matmul_chk #(
   parameter int N  = 4,
   parameter int DW = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 feed_en_o,
   input logic [$clog2(N)-1:0] feed_k_o,
   input logic                 busy_o,
   input logic                 res_valid_o,
   input logic [$clog2(N)-1:0] res_row_o,
   input logic                 done_o,
   input logic [N*DW-1:0]      east_edge,
   input logic [N*DW-1:0]      south_edge
);

   localparam int KW = $clog2(N);

   // R2
   feed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_en_o && feed_k_o != '0) |-> ($past(feed_en_o) && feed_k_o == KW'($past(feed_k_o) + 1'b1)));

   // R2
   feed_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (feed_en_o && feed_k_o == '0));

   // R4
   drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid_o) |-> (res_row_o == KW'(N - 1)));

   // R4
   drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && $past(res_valid_o)) |-> (res_row_o == KW'($past(res_row_o) - 1'b1)));

   // R5
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(res_valid_o) && $past(res_row_o) == '0 && busy_o));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R6
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !(feed_en_o && feed_k_o == '0 && $past(busy_o) && !$rose(busy_o)));

   // R7
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && $past(res_valid_o)) |-> (east_edge == '0 && south_edge == '0));

endmodule

bind mesh_matmul mesh_matmul_chk #(.N(N), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .feed_en_o   (feed_en_o),
   .feed_k_o    (feed_k_o),
   .busy_o      (busy_o),
   .res_valid_o (res_valid_o),
   .res_row_o   (res_row_o),
   .done_o      (done_o),
   .east_edge   (east_edge),
   .south_edge  (south_edge)
);

// File: tb/mesh_matmul_tb_top.sv
module mesh_matmul_tb_top;

   localparam int  N  = 4;
   localparam int  DW = 8;
   localparam int  AW = 20;
   localparam int  KW = $clog2(N);
   localparam time CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic [N*DW-1:0]   top_row_i;
   logic [N*DW-1:0]   left_col_i;
   logic              feed_en_o;
   logic [KW-1:0]     feed_k_o;
   logic              busy_o;
   logic              res_valid_o;
   logic [KW-1:0]     res_row_o;
   logic [N*AW-1:0]   res_data_o;
   logic              done_o;

   int U [N][N];
   int V [N][N];
   int R [N][N];
   int junk_mode = 0;
   int s = -1;
   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mesh_matmul #(.N(N), .DW(DW), .AW(AW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .top_row_i   (top_row_i),
      .left_col_i  (left_col_i),
      .feed_en_o   (feed_en_o),
      .feed_k_o    (feed_k_o),
      .busy_o      (busy_o),
      .res_valid_o (res_valid_o),
      .res_row_o   (res_row_o),
      .res_data_o  (res_data_o),
      .done_o      (done_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic [DW-1:0] filler();
      case (junk_mode)
         0:       return '0;
         1:       return '1;
         default: return DW'($urandom);
      endcase
   endfunction

   // operand driver: follows the feed request, junk elsewhere (R7)
   always @(negedge clk) begin
      for (int j = 0; j < N; j++) begin
         if (feed_en_o) begin
            top_row_i[j*DW +: DW]  = DW'(U[feed_k_o][j]);
            left_col_i[j*DW +: DW] = DW'(V[j][feed_k_o]);
         end else begin
            top_row_i[j*DW +: DW]  = filler();
            left_col_i[j*DW +: DW] = filler();
         end
      end
   end

   // reference model: edges since accepted start
   always @(posedge clk) begin
      if (!rst_n) begin
         s = -1;
      end else if (s < 0) begin
         if (start_i) begin
            s = 0;
            for (int i = 0; i < N; i++)
               for (int j = 0; j < N; j++) begin
                  R[i][j] = 0;
                  for (int k = 0; k < N; k++) R[i][j] += V[i][k] * U[k][j];
               end
         end
      end else begin
         s++;
         if (s > 4*N-2) s = -1;
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit exp_feed, exp_rv;
         int row;
         exp_feed = (s >= 0) && (s < N);
         exp_rv   = (s >= 3*N-2) && (s <= 4*N-3);
         chk("R5 busy", int'(busy_o), int'(s >= 0));
         chk("R5 done", int'(done_o), int'(s == 4*N-2));
         chk("R2 feed_en", int'(feed_en_o), int'(exp_feed));
         if (exp_feed) chk("R2 feed_k", int'(feed_k_o), s);
         chk("R4 res_valid", int'(res_valid_o), int'(exp_rv));
         if (exp_rv) begin
            row = N-1-(s-(3*N-2));
            chk("R4 res_row", int'(res_row_o), row);
            for (int j = 0; j < N; j++)
               chk("R3 R7 R8 result", int'($signed(res_data_o[j*AW +: AW])), R[row][j]);
         end
      end
   end

   task automatic wait_done();
      do @(negedge clk); while (!done_o);
   endtask

   task automatic run_job();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         report();
      end
   end

   initial begin
      rst_n      = 1'b0;
      start_i    = 1'b0;
      top_row_i  = '0;
      left_col_i = '0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            U[i][j] = 0;
            V[i][j] = 0;
         end
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 done", int'(done_o), 0);
      chk("R1 res_valid", int'(res_valid_o), 0);
      chk("R1 feed_en", int'(feed_en_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", int'(busy_o), 0);

      // R3: identity times ramp
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            V[i][j] = (i == j) ? 1 : 0;
            U[i][j] = i * N + j - 5;
         end
      junk_mode = 0;
      run_job();

      // R3 R7: random operands, all-ones junk
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            V[i][j] = int'($signed(DW'($urandom)));
            U[i][j] = int'($signed(DW'($urandom)));
         end
      junk_mode = 1;
      run_job();

      // R3 R7: extremes, random junk
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            V[i][j] = (j % 2 == 0) ? -128 : 127;
            U[i][j] = (i == j) ? 127 : -128;
         end
      junk_mode = 2;
      run_job();
      chk("R5 idle after job", int'(busy_o), 0);

      // R6 R8: start held high through a job -> ignored while busy, then a follow-on job
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            V[i][j] = int'($signed(DW'($urandom)));
            U[i][j] = int'($signed(DW'($urandom)));
         end
      @(negedge clk);
      start_i = 1'b1;
      wait_done();
      wait_done();
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      chk("R6 idle after held start", int'(busy_o), 0);

      // R8: different operands straight after
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            V[i][j] = i - j;
            U[i][j] = 2 * j + i;
         end
      junk_mode = 1;
      run_job();

      report();
   end

endmodule